// File: doc/BRIEF.md
# USB Host Interrupt Status Register

This block keeps the interrupt status byte of a USB host controller. Five kinds of event are captured into sticky flags: completion of transfer channel A, completion of transfer channel B, the frame-start timer tick, a cable attach or detach, and a resume signal from the bus. Next to these flags the byte carries two live fields. One is the current D+ line level. The other is either a device-absent indication or the latched resume flag, depending on a mode input taken from a control register.

Software reads the byte on `stat_byte` and clears flags by writing a byte to address 0x0D. Each 1 in the written data clears the flag at that bit position. The bus line state (SE0 or idle) is synchronised and then filtered by a programmable stability count before it is used, so that short glitches do not count as an attach or a detach. A single interrupt line, `irq`, goes high when any sticky flag is set and its bit is also set in the enable mask.

The register port is plain control and status. It is a one-cycle write strobe with address and data, and it has no back-pressure. The event inputs are single-cycle pulses with no handshake.

Top module: `usbh_irq_status`

## Requirements
- R1: After reset, `stat_byte` reads 0x40 (no device present, presence mode, no flags set) and `irq` is 0.
- R2: A write with `wr_addr` = 0x0D clears each sticky flag whose bit is 1 in `wr_data`. Flags whose bit is written as 0 keep their value. Writes to any other address change nothing.
- R3: If a flag's set event and its clear arrive in the same clock cycle, the flag reads 1 afterwards.
- R4: Bit 7 shows the `dplus` input level after two clocks of synchronisation. It is never latched.
- R5: With `resume_mode` = 1, bit 6 is a sticky flag. It is set by a `resume_pulse` and cleared by writing 1 to bit 6.
- R6: With `resume_mode` = 0, bit 6 reads 1 when the filtered line state is SE0 and 0 when it is idle. Resume pulses are ignored, and the resume flag is held at 0, so it reads 0 on return to resume mode.
- R7: Bit 5 is set whenever the filtered line state changes, in either direction: SE0 to idle, or idle to SE0.
- R8: The filtered line state takes a new value only after the synchronised `line_se0` has differed from it on `stable_len` consecutive clocks. A value of 0 is treated as 1. A shorter excursion leaves both bit 5 and bit 6 unchanged. With a count of N, bit 5 reads 1 from N+2 clocks after the input changes.
- R9: Bit 4 is set by `sof_tick`, bit 1 by `done_b`, and bit 0 by `done_a`.
- R10: Bits 3 and 2 always read 0, whatever is written.
- R11: `irq` is the OR, over the sticky flags (bits 0, 1, 4, 5, and bit 6 in resume mode only), of flag AND `irq_mask`. Bit 7, and bit 6 in presence mode, never raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Write data; a 1 clears the matching flag |
| line_se0 | input | 1 | Sampled bus state: 1 = SE0, 0 = idle (asynchronous) |
| dplus | input | 1 | D+ line level (asynchronous) |
| done_a | input | 1 | Transfer channel A done pulse |
| done_b | input | 1 | Transfer channel B done pulse |
| sof_tick | input | 1 | Frame-start timer pulse |
| resume_pulse | input | 1 | Resume detected pulse |
| resume_mode | input | 1 | Control bit: 1 = bit 6 is the resume flag |
| stable_len | input | 8 | Clocks the line state must hold before it is accepted |
| irq_mask | input | 8 | Per-bit interrupt enables |
| stat_byte | output | 8 | Status byte |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that the event inputs, `resume_mode`, `stable_len` and `irq_mask` are synchronous to `clk`, and that only `line_se0` and `dplus` change asynchronously. The bench respects this by driving every input on the falling edge. It holds `stable_len` constant while a line change is being filtered, and it toggles `resume_mode` only between scenarios, never in the same cycle as a resume pulse.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;
  // Status byte bit positions (software decodes these)
  localparam int unsigned POS_DONE_A = 0;
  localparam int unsigned POS_DONE_B = 1;
  localparam int unsigned POS_FRAME  = 4;
  localparam int unsigned POS_ATTACH = 5;
  localparam int unsigned POS_DEV    = 6;
  localparam int unsigned POS_DPLUS  = 7;

  // Sticky flag indices inside the latch bank
  localparam int unsigned FLG_DONE_A = 0;
  localparam int unsigned FLG_DONE_B = 1;
  localparam int unsigned FLG_FRAME  = 2;
  localparam int unsigned FLG_ATTACH = 3;
  localparam int unsigned FLG_RESUME = 4;
  localparam int unsigned NUM_FLAGS  = 5;

  localparam logic [7:0] STATUS_ADDR = 8'h0D;
endpackage

// File: rtl/usbh_sync2.sv
module usbh_sync2 #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/usbh_line_filter.sv
module usbh_line_filter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  input  logic [CW-1:0] len_i,
  output logic          state_o,
  output logic          flip_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_eff;
  logic          differs;

  assign len_eff = (len_i == '0) ? {{(CW-1){1'b0}}, 1'b1} : len_i;
  assign differs = (line_i != state_o);
  assign flip_o  = differs && (cnt_q == len_eff - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o <= 1'b1;
      cnt_q   <= '0;
    end else begin
      if (flip_o) state_o <= line_i;
      if (!differs || flip_o) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_STATE_NEEDS_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != $past(state_o)) |-> $past(flip_o)); // R8
  AST_FLIP_TAKES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    flip_o |=> (state_o == $past(line_i))); // R7
endmodule

// File: rtl/usbh_flag_bank.sv
module usbh_flag_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] zap_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_o[i] <= 1'b0;
      else if (zap_i[i]) flag_o[i] <= 1'b0;
      else               flag_o[i] <= set_i[i] | (flag_o[i] & ~clr_i[i]);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[i] && !zap_i[i]) |=> flag_o[i]); // R3
    AST_W1C_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]); // R2
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[i] && !clr_i[i] && !zap_i[i]) |=> (flag_o[i] == $past(flag_o[i]))); // R2
  end
endmodule

// File: rtl/usbh_irq_status.sv
module usbh_irq_status
  import usbh_irq_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             line_se0,
  input  logic             dplus,
  input  logic             done_a,
  input  logic             done_b,
  input  logic             sof_tick,
  input  logic             resume_pulse,
  input  logic             resume_mode,
  input  logic [LEN_W-1:0] stable_len,
  input  logic [7:0]       irq_mask,
  output logic [7:0]       stat_byte,
  output logic             irq
);
  logic [1:0]           sync_q;
  logic                 line_s, dplus_s;
  logic                 line_state, line_flip;
  logic [7:0]           clr_byte;
  logic [NUM_FLAGS-1:0] set_v, clr_v, zap_v, flags;
  logic [7:0]           sticky;

  usbh_sync2 #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({line_se0, dplus}), .q(sync_q)
  );
  assign line_s  = sync_q[1];
  assign dplus_s = sync_q[0];

  usbh_line_filter #(.CW(LEN_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .line_i(line_s), .len_i(stable_len),
    .state_o(line_state), .flip_o(line_flip)
  );

  assign clr_byte = (wr_en && wr_addr == STATUS_ADDR) ? wr_data : 8'h00;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    zap_v = '0;
    set_v[FLG_DONE_A] = done_a;
    set_v[FLG_DONE_B] = done_b;
    set_v[FLG_FRAME]  = sof_tick;
    set_v[FLG_ATTACH] = line_flip;
    set_v[FLG_RESUME] = resume_pulse & resume_mode;
    clr_v[FLG_DONE_A] = clr_byte[POS_DONE_A];
    clr_v[FLG_DONE_B] = clr_byte[POS_DONE_B];
    clr_v[FLG_FRAME]  = clr_byte[POS_FRAME];
    clr_v[FLG_ATTACH] = clr_byte[POS_ATTACH];
    clr_v[FLG_RESUME] = clr_byte[POS_DEV];
    zap_v[FLG_RESUME] = ~resume_mode;
  end

  usbh_flag_bank #(.N(NUM_FLAGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .zap_i(zap_v),
    .flag_o(flags)
  );

  always_comb begin
    sticky             = 8'h00;
    sticky[POS_DONE_A] = flags[FLG_DONE_A];
    sticky[POS_DONE_B] = flags[FLG_DONE_B];
    sticky[POS_FRAME]  = flags[FLG_FRAME];
    sticky[POS_ATTACH] = flags[FLG_ATTACH];
    sticky[POS_DEV]    = resume_mode & flags[FLG_RESUME];
    stat_byte           = sticky;
    stat_byte[POS_DEV]  = resume_mode ? flags[FLG_RESUME] : line_state;
    stat_byte[POS_DPLUS] = dplus_s;
  end

  assign irq = |(sticky & irq_mask);

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte[3:2] == 2'b00); // R10
  AST_DPLUS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte[POS_DPLUS] == sync_q[0]); // R4
  AST_PRESENCE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !resume_mode |-> (stat_byte[POS_DEV] == line_state)); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0)); // R11
endmodule

// File: tb/sim_usbh_irq_status.sv
module sim_usbh_irq_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       line_se0 = 1'b1;
  logic       dplus = 1'b0;
  logic       done_a = 1'b0, done_b = 1'b0, sof_tick = 1'b0, resume_pulse = 1'b0;
  logic       resume_mode = 1'b0;
  logic [7:0] stable_len = 8'd4;
  logic [7:0] irq_mask = 8'h00;
  logic [7:0] stat_byte;
  logic       irq;

  int checks = 0;
  int errors = 0;

  usbh_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .line_se0(line_se0), .dplus(dplus), .done_a(done_a), .done_b(done_b),
    .sof_tick(sof_tick), .resume_pulse(resume_pulse), .resume_mode(resume_mode),
    .stable_len(stable_len), .irq_mask(irq_mask), .stat_byte(stat_byte), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic t_reset;
    chk("R1 status", stat_byte, 8'h40);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_done_clear;
    done_a = 1; tick(1); done_a = 0;
    chk("R9 done_a", stat_byte, 8'h41);
    done_b = 1; sof_tick = 1; tick(1); done_b = 0; sof_tick = 0;
    chk("R9 done_b sof", stat_byte, 8'h53);
    reg_write(8'h0D, 8'h01);
    chk("R2 clear bit0 only", stat_byte, 8'h52);
    reg_write(8'h05, 8'hFF);
    chk("R2 other address ignored", stat_byte, 8'h52);
    reg_write(8'h0D, 8'h12);
    chk("R2 clear rest", stat_byte, 8'h40);
  endtask

  task automatic t_set_wins;
    done_b = 1; wr_en = 1; wr_addr = 8'h0D; wr_data = 8'h02;
    tick(1);
    done_b = 0; wr_en = 0; wr_data = 0;
    chk("R3 set beats clear", stat_byte, 8'h42);
    reg_write(8'h0D, 8'h02);
    chk("R3 later clear", stat_byte, 8'h40);
  endtask

  task automatic t_reserved;
    reg_write(8'h0D, 8'h0C);
    done_a = 1; done_b = 1; sof_tick = 1; tick(1);
    done_a = 0; done_b = 0; sof_tick = 0;
    chk("R10 reserved zero", stat_byte & 8'h0C, 8'h00);
    reg_write(8'h0D, 8'hFF);
    chk("R10 after clear", stat_byte, 8'h40);
  endtask

  task automatic t_dplus;
    dplus = 1; tick(1);
    chk("R4 not yet", stat_byte & 8'h80, 8'h00);
    tick(1);
    chk("R4 dplus high", stat_byte & 8'h80, 8'h80);
    reg_write(8'h0D, 8'h80);
    chk("R4 not clearable", stat_byte & 8'h80, 8'h80);
    dplus = 0; tick(2);
    chk("R4 dplus low", stat_byte & 8'h80, 8'h00);
  endtask

  task automatic t_irq_mask;
    dplus = 1; irq_mask = 8'hC0; tick(3);
    chk("R11 live bits no irq", {7'b0, irq}, 8'h00);
    done_a = 1; tick(1); done_a = 0;
    chk("R11 masked off", {7'b0, irq}, 8'h00);
    irq_mask = 8'h01; tick(1);
    chk("R11 enabled", {7'b0, irq}, 8'h01);
    reg_write(8'h0D, 8'h01);
    chk("R11 drops after clear", {7'b0, irq}, 8'h00);
    irq_mask = 8'h00; dplus = 0; tick(2);
  endtask

  task automatic t_resume;
    resume_mode = 1; irq_mask = 8'h40; tick(1);
    chk("R5 resume flag clear", stat_byte & 8'h40, 8'h00);
    resume_pulse = 1; tick(1); resume_pulse = 0;
    chk("R5 resume set", stat_byte & 8'h40, 8'h40);
    chk("R11 resume irq", {7'b0, irq}, 8'h01);
    reg_write(8'h0D, 8'h40);
    chk("R5 resume cleared", stat_byte & 8'h40, 8'h00);
    resume_pulse = 1; tick(1); resume_pulse = 0;
    resume_mode = 0; tick(1);
    chk("R6 presence shown", stat_byte & 8'h40, 8'h40);
    chk("R11 presence no irq", {7'b0, irq}, 8'h00);
    resume_pulse = 1; tick(1); resume_pulse = 0;
    resume_mode = 1; tick(1);
    chk("R6 resume held zero", stat_byte & 8'h40, 8'h00);
    resume_mode = 0; irq_mask = 8'h00; tick(1);
  endtask

  task automatic t_attach;
    stable_len = 8'd4;
    line_se0 = 0; tick(5);
    chk("R8 not before N+2", stat_byte, 8'h40);
    tick(1);
    chk("R7 attach", stat_byte, 8'h20);
    reg_write(8'h0D, 8'h20);
    chk("R7 attach cleared", stat_byte, 8'h00);
    line_se0 = 1; tick(6);
    chk("R7 detach", stat_byte, 8'h60);
    reg_write(8'h0D, 8'h20);
    chk("R6 absent after detach", stat_byte, 8'h40);
  endtask

  task automatic t_glitch;
    stable_len = 8'd4;
    line_se0 = 0; tick(3); line_se0 = 1; tick(12);
    chk("R8 short glitch ignored", stat_byte, 8'h40);
    stable_len = 8'd0;
    line_se0 = 0; tick(3);
    chk("R8 zero length acts as one", stat_byte, 8'h20);
    reg_write(8'h0D, 8'h20);
    line_se0 = 1; tick(3);
    reg_write(8'h0D, 8'h20);
    chk("R8 back to absent", stat_byte, 8'h40);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_done_clear();
    t_set_wins();
    t_reserved();
    t_dplus();
    t_irq_mask();
    t_resume();
    t_attach();
    t_glitch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule